// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside a DRAM access sequencer and supplies the column address for each memory cycle. When an access is opened by the address strobe together with chip select, the block captures the incoming column address, row and bank. During a CPU burst, each selected transition of the transfer acknowledge moves the column address one step forward. The step either wraps inside an aligned block of 2, 4, 8 or 16 locations or, when the no-wrap control is high, runs linearly across the page.

The block also produces a page-miss flag for the sequencer. In computed mode the flag comes from comparing each new access against the row and bank stored at the previous opening access. A linear burst that has run off the end of the page also raises it. In external mode the flag is taken from an input pin and is passed through only while a qualified address strobe is present. A configuration bit selects a fall-through mode. In that mode the column input passes straight to the output and bursting is disabled.

Top module: `burstColGen`

## Requirements
- R1: While reset is asserted and after its release, with no access opened, colOut is 0 and pageMiss is 0 (computed page-miss mode).
- R2: In latch mode (cfgLatchMode=1), at a clock edge where addrStrobe=1 and chipSel=1, colIn is captured and appears on colOut from the next cycle on. An addrStrobe with chipSel=0 changes nothing.
- R3: A burst step is taken at a clock edge only while the burst request is active and ackIn has made the selected transition since the previous edge. The burst request is active when burstReq equals cfgBurstHigh (1 = active high, 0 = active low). The selected transition is 0 to 1 when cfgAckFalling=0 and 1 to 0 when cfgAckFalling=1. Each transition gives exactly one step.
- R4: With noWrap=0, a step increments only the low burstLen+1 column bits (burstLen 0,1,2,3 = blocks of 2,4,8,16). These bits wrap to zero, and the upper bits are left unchanged.
- R5: With noWrap=1, a step adds one to the whole 12-bit column address, modulo 4096.
- R6: Without a qualified step or load, including on an acknowledge transition of the unselected direction, colOut holds its value.
- R7: With cfgLatchMode=0, colOut equals colIn in the same cycle, and acknowledge transitions cause no steps.
- R8: In computed mode (cfgMissOutput=1), from the cycle after an opening access, pageMiss is 1 when that access is the first since reset, when its row or bank differs from the ones stored at the previous opening access, or when a linear burst crossed the page end since then. Otherwise it is 0. The value holds until the next opening access.
- R9: In computed mode, a linear step from column 4095 raises pageMiss from the next cycle. Any other step leaves it unchanged.
- R10: In external mode (cfgMissOutput=0), pageMiss equals pageMissIn while addrStrobe=1 and chipSel=1, and is 0 otherwise, within the same cycle.
- R11: When an opening access and a qualified acknowledge transition fall on the same edge, the load wins. That transition is consumed and causes no step later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrStrobe | input | 1 | Access start strobe |
| chipSel | input | 1 | Qualifies addrStrobe |
| rowIn | input | 12 | Row address of the access |
| colIn | input | 12 | Column address of the access |
| bankIn | input | 2 | Bank select of the access |
| burstReq | input | 1 | Burst request, polarity set by cfgBurstHigh |
| noWrap | input | 1 | 1 = linear burst, 0 = wrapping burst |
| burstLen | input | 2 | Wrap block size code: 0=2, 1=4, 2=8, 3=16 |
| ackIn | input | 1 | Transfer acknowledge whose transitions advance the burst |
| cfgLatchMode | input | 1 | 1 = latch mode, 0 = fall-through |
| cfgBurstHigh | input | 1 | 1 = burst request active high |
| cfgAckFalling | input | 1 | 1 = step on falling acknowledge, 0 = rising |
| cfgMissOutput | input | 1 | 1 = compute page miss, 0 = take pageMissIn |
| pageMissIn | input | 1 | External page-miss indication |
| colOut | output | 12 | Current column address |
| pageMiss | output | 1 | Page-miss flag |

## Verification
A new opening access and a qualified acknowledge transition can land on the same clock edge. Both would write the column register. The bench drives a strobe with chip select in the same cycle as an acknowledge transition of the selected direction, with the burst request active. It then expects the fresh column input on the next cycle and no step on the cycle after, which shows the transition was not held over. A linear step out of column 4095 also makes the page-crossing update to the miss flag meet the comparison done at the next opening access. This is judged by a per-cycle reference model and by directed checks on both sides of the crossing.

// File: rtl/burstColPkg.sv
package burstColPkg;
  typedef struct packed {
    logic load;     // open a new access: capture column, row, bank
    logic advance;  // take one burst step
  } colStrobeT;
endpackage

// File: rtl/burstColCtrl.sv
module burstColCtrl
  import burstColPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrStrobe,
  input  logic      chipSel,
  input  logic      burstReq,
  input  logic      cfgBurstHigh,
  input  logic      ackIn,
  input  logic      cfgAckFalling,
  input  logic      cfgLatchMode,
  output colStrobeT strb
);
  logic ackPrev;
  logic ackRise;
  logic ackFall;
  logic ackHit;
  logic burstActive;
  logic startHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackPrev <= 1'b0;
    else       ackPrev <= ackIn;
  end

  always_comb begin
    ackRise     = ackIn & ~ackPrev;
    ackFall     = ~ackIn & ackPrev;
    ackHit      = cfgAckFalling ? ackFall : ackRise;
    burstActive = (burstReq == cfgBurstHigh);
    startHit    = addrStrobe & chipSel;
    strb.load    = startHit;
    strb.advance = ~startHit & cfgLatchMode & burstActive & ackHit;
  end
endmodule

// File: rtl/burstColPath.sv
module burstColPath
  import burstColPkg::*;
#(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  colStrobeT         strb,
  input  logic [COL_W-1:0]  colIn,
  input  logic [ROW_W-1:0]  rowIn,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              noWrap,
  input  logic [LEN_W-1:0]  burstLen,
  input  logic              cfgLatchMode,
  input  logic              cfgMissOutput,
  input  logic              pageMissIn,
  input  logic              addrStrobe,
  input  logic              chipSel,
  output logic [COL_W-1:0]  colOut,
  output logic              pageMiss
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0]  colReg;
  logic [ROW_W-1:0]  prevRow;
  logic [BANK_W-1:0] prevBank;
  logic              opened;
  logic              missFlag;
  logic              crossPend;
  logic [COL_W-1:0]  wrapMask;
  logic [COL_W-1:0]  colInc;
  logic [COL_W-1:0]  colStep;
  logic              pageEnd;
  logic              missCalc;

  // one mask bit per column bit: set when the bit lies inside the wrap block
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign wrapMask[i] = (32'(burstLen) >= i);
  end

  always_comb begin
    colInc   = colReg + ONE;
    colStep  = noWrap ? colInc : ((colReg & ~wrapMask) | (colInc & wrapMask));
    pageEnd  = &colReg;
    missCalc = ~opened | (rowIn != prevRow) | (bankIn != prevBank) | crossPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colReg    <= '0;
      prevRow   <= '0;
      prevBank  <= '0;
      opened    <= 1'b0;
      missFlag  <= 1'b0;
      crossPend <= 1'b0;
    end else if (strb.load) begin
      colReg    <= colIn;
      prevRow   <= rowIn;
      prevBank  <= bankIn;
      opened    <= 1'b1;
      missFlag  <= missCalc;
      crossPend <= 1'b0;
    end else if (strb.advance) begin
      colReg <= colStep;
      if (noWrap && pageEnd) begin
        missFlag  <= 1'b1;
        crossPend <= 1'b1;
      end
    end
  end

  always_comb begin
    colOut   = cfgLatchMode ? colReg : colIn;
    pageMiss = cfgMissOutput ? missFlag : (pageMissIn & addrStrobe & chipSel);
  end
endmodule

// File: rtl/burstColGen.sv
module burstColGen
  import burstColPkg::*;
#(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic              chipSel,
  input  logic [ROW_W-1:0]  rowIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              burstReq,
  input  logic              noWrap,
  input  logic [LEN_W-1:0]  burstLen,
  input  logic              ackIn,
  input  logic              cfgLatchMode,
  input  logic              cfgBurstHigh,
  input  logic              cfgAckFalling,
  input  logic              cfgMissOutput,
  input  logic              pageMissIn,
  output logic [COL_W-1:0]  colOut,
  output logic              pageMiss
);
  colStrobeT strb;

  burstColCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addrStrobe   (addrStrobe),
    .chipSel      (chipSel),
    .burstReq     (burstReq),
    .cfgBurstHigh (cfgBurstHigh),
    .ackIn        (ackIn),
    .cfgAckFalling(cfgAckFalling),
    .cfgLatchMode (cfgLatchMode),
    .strb         (strb)
  );

  burstColPath #(
    .COL_W (COL_W),
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .LEN_W (LEN_W)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .colIn        (colIn),
    .rowIn        (rowIn),
    .bankIn       (bankIn),
    .noWrap       (noWrap),
    .burstLen     (burstLen),
    .cfgLatchMode (cfgLatchMode),
    .cfgMissOutput(cfgMissOutput),
    .pageMissIn   (pageMissIn),
    .addrStrobe   (addrStrobe),
    .chipSel      (chipSel),
    .colOut       (colOut),
    .pageMiss     (pageMiss)
  );
endmodule

// File: rtl/burstColChk.sv
module burstColChk #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             addrStrobe,
  input logic             chipSel,
  input logic [COL_W-1:0] colIn,
  input logic [COL_W-1:0] colOut,
  input logic             noWrap,
  input logic             cfgLatchMode,
  input logic             cfgMissOutput,
  input logic             pageMiss,
  input logic             advStrobe
);
  p_load_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && chipSel) |=> (!cfgLatchMode || colOut == $past(colIn)));

  p_wrap_upper_r4: assert property (@(posedge clk) disable iff (!rstN)
    (advStrobe && !noWrap) |=>
      (!cfgLatchMode || colOut[COL_W-1:4] == $past(colOut[COL_W-1:4])));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (advStrobe && noWrap) |=> (!cfgLatchMode || colOut == $past(colOut) + COL_W'(1)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLatchMode && !(addrStrobe && chipSel) && !advStrobe) |=>
      (!cfgLatchMode || $stable(colOut)));

  p_page_cross_r9: assert property (@(posedge clk) disable iff (!rstN)
    (advStrobe && noWrap && cfgLatchMode && (&colOut)) |=> (!cfgMissOutput || pageMiss));

  p_ext_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMissOutput && !(addrStrobe && chipSel)) |-> !pageMiss);
endmodule

bind burstColGen burstColChk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .addrStrobe   (addrStrobe),
  .chipSel      (chipSel),
  .colIn        (colIn),
  .colOut       (colOut),
  .noWrap       (noWrap),
  .cfgLatchMode (cfgLatchMode),
  .cfgMissOutput(cfgMissOutput),
  .pageMiss     (pageMiss),
  .advStrobe    (strb.advance)
);

// File: tb/burstColGen_test.sv
module burstColGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        as = 1'b0, cs = 1'b0;
  logic [11:0] row = '0, col = '0;
  logic [1:0]  bank = '0, len = '0;
  logic        breq = 1'b0, nw = 1'b0, ack = 1'b0;
  logic        latchM = 1'b1, bHigh = 1'b1, aFall = 1'b0, missOut = 1'b1, pmIn = 1'b0;
  logic [11:0] colOut;
  logic        pageMiss;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mCol = 0, mRow = 0, mBank = 0;
  bit mOpened = 0, mMiss = 0, mPend = 0, mAckPrev = 0;

  always #10 clk = ~clk;

  burstColGen uut (
    .clk(clk), .rstN(rstN), .addrStrobe(as), .chipSel(cs),
    .rowIn(row), .colIn(col), .bankIn(bank), .burstReq(breq),
    .noWrap(nw), .burstLen(len), .ackIn(ack), .cfgLatchMode(latchM),
    .cfgBurstHigh(bHigh), .cfgAckFalling(aFall), .cfgMissOutput(missOut),
    .pageMissIn(pmIn), .colOut(colOut), .pageMiss(pageMiss)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of the requirements, updated on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCol = 0; mRow = 0; mBank = 0; mOpened = 0; mMiss = 0; mPend = 0; mAckPrev = 0;
    end else begin
      bit act, hit;
      int blk;
      act = (breq == bHigh);
      hit = aFall ? (mAckPrev && !ack) : (!mAckPrev && ack);
      if (as && cs) begin
        mMiss = !mOpened || (int'(row) != mRow) || (int'(bank) != mBank) || mPend;
        mPend = 0; mOpened = 1;
        mCol = col; mRow = row; mBank = bank;
      end else if (latchM && act && hit) begin
        if (nw) begin
          if (mCol == 4095) begin mMiss = 1; mPend = 1; end
          mCol = (mCol + 1) % 4096;
        end else begin
          blk = 2 << len;
          mCol = (mCol / blk) * blk + ((mCol % blk) + 1) % blk;
        end
      end
      mAckPrev = ack;
    end
  end

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      check("model colOut", int'(colOut), latchM ? mCol : int'(col));
      check("model pageMiss", int'(pageMiss),
            missOut ? int'(mMiss) : int'(pmIn && as && cs));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #3;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    check("R1 colOut in reset", int'(colOut), 0);
    check("R1 pageMiss in reset", int'(pageMiss), 0);
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R1 colOut after reset", int'(colOut), 0);
    check("R1 pageMiss after reset", int'(pageMiss), 0);

    // first opening access, wrap block of 4
    as = 1; cs = 1; row = 12'h005; bank = 2'd1; col = 12'h123; len = 2'd1; nw = 0;
    tick(); as = 0;
    check("R2 load", int'(colOut), 'h123);
    check("R8 first access miss", int'(pageMiss), 1);
    breq = 1; ack = 1; tick();
    check("R4 wrap in block of 4", int'(colOut), 'h120);
    ack = 0; tick();
    check("R6 unselected edge holds", int'(colOut), 'h120);
    ack = 1; tick();
    check("R3 rising step", int'(colOut), 'h121);

    // strobe without chip select
    cs = 0; as = 1; col = 12'h7AA; tick(); as = 0;
    check("R2 strobe without select ignored", int'(colOut), 'h121);

    // same page, linear burst
    as = 1; cs = 1; col = 12'h0FE; nw = 1; ack = 0; tick(); as = 0;
    check("R2 load linear start", int'(colOut), 'h0FE);
    check("R8 same page no miss", int'(pageMiss), 0);
    ack = 1; tick();
    check("R5 linear step", int'(colOut), 'h0FF);
    ack = 0; tick(); ack = 1; tick();
    check("R5 linear past block", int'(colOut), 'h100);
    check("R9 no crossing flag", int'(pageMiss), 0);

    // burst request polarity
    bHigh = 0; ack = 0; tick(); ack = 1; tick();
    check("R3 inactive request no step", int'(colOut), 'h100);
    breq = 0; ack = 0; tick(); ack = 1; tick();
    check("R3 active-low request step", int'(colOut), 'h101);

    // falling acknowledge selected
    aFall = 1; bHigh = 1; breq = 1; ack = 0; tick();
    check("R3 falling step", int'(colOut), 'h102);
    ack = 1; tick();
    check("R6 rising ignored when falling selected", int'(colOut), 'h102);

    // page end crossing
    as = 1; cs = 1; col = 12'hFFF; tick(); as = 0;
    check("R8 same page at FFF", int'(pageMiss), 0);
    ack = 0; tick();
    check("R5 wrap modulo 4096", int'(colOut), 'h000);
    check("R9 crossing raises miss", int'(pageMiss), 1);
    ack = 1; tick();
    as = 1; cs = 1; col = 12'h010; tick(); as = 0;
    check("R8 pending crossing miss", int'(pageMiss), 1);
    check("R2 load after crossing", int'(colOut), 'h010);

    // load and qualified edge together
    as = 1; cs = 1; col = 12'h234; ack = 0; tick(); as = 0;
    check("R11 load wins", int'(colOut), 'h234);
    check("R8 pending cleared", int'(pageMiss), 0);
    tick();
    check("R11 edge consumed", int'(colOut), 'h234);

    // wrap sizes 16, 8, 2
    nw = 0; len = 2'd3; as = 1; cs = 1; col = 12'h01F; tick(); as = 0;
    ack = 1; tick(); ack = 0; tick();
    check("R4 wrap in block of 16", int'(colOut), 'h010);
    len = 2'd2; as = 1; col = 12'h0A7; tick(); as = 0;
    ack = 1; tick(); ack = 0; tick();
    check("R4 wrap in block of 8", int'(colOut), 'h0A0);
    len = 2'd0; as = 1; col = 12'h055; tick(); as = 0;
    ack = 1; tick(); ack = 0; tick();
    check("R4 wrap in block of 2", int'(colOut), 'h054);

    // row and bank changes
    as = 1; cs = 1; row = 12'h006; col = 12'h000; tick(); as = 0;
    check("R8 row change miss", int'(pageMiss), 1);
    as = 1; bank = 2'd2; tick(); as = 0;
    check("R8 bank change miss", int'(pageMiss), 1);
    as = 1; tick(); as = 0;
    check("R8 repeat access hit", int'(pageMiss), 0);

    // fall-through
    latchM = 0; col = 12'h3C5; #1;
    check("R7 fall-through passes column", int'(colOut), 'h3C5);
    ack = 1; tick(); ack = 0; tick();
    check("R7 fall-through still follows", int'(colOut), 'h3C5);
    latchM = 1; #1;
    check("R7 no steps while fall-through", int'(colOut), 'h000);

    // external page miss
    missOut = 0; pmIn = 1; as = 0; cs = 1; #1;
    check("R10 gated without strobe", int'(pageMiss), 0);
    as = 1; #1;
    check("R10 passes while qualified", int'(pageMiss), 1);
    cs = 0; #1;
    check("R10 gated without select", int'(pageMiss), 0);
    cs = 1; pmIn = 0; #1;
    check("R10 follows input low", int'(pageMiss), 0);
    as = 0; tick(); tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule